// File: doc/BRIEF.md
# Pad Delay Recalibration Sequencer

This block is a hardware controller that walks the full pad delay recalibration flow once the core supply has been moved to a new level. A single start pulse launches it. It then acts as a bus master on a simple request/response port: it unlocks the delay configuration space, retunes the reference clock period field, runs the calibration, isolates the pads, reloads the calibrated values, asks an external agent to program the pad multiplexing, and releases the pads again. It finishes by relocking the configuration space.

Every completion wait is a poll loop bounded by the `POLL_TRIES` parameter. A poll that runs out of attempts fails its step. The rest of the flow is then skipped, but the relock write is still issued. At the end the block gives a one-cycle `done` pulse, a `pass` flag and a one-hot `err_code`. The flag and the code stay put until the next accepted start.

The request channel follows valid/ready rules. Once `bus_req_valid` is raised, the request stays stable until the cycle in which `bus_req_ready` is high. Only one request is ever outstanding. Each accepted request, read or write, is answered by exactly one `bus_rsp_valid` cycle. The master always accepts responses, so the response side has no back-pressure. The pad-mux agent uses a level handshake: `mux_req` stays high until `mux_ack` is seen high on a clock edge.

Top module: `iodly_recal_seq`

## Requirements
- R1: After every accepted start, the first bus access is a write of 0x0000AAAA to `CFG_BASE`+0x2C. The last access is a write of 0x0000AAAB to the same address, and it is issued on success and on every failure path.
- R2: The second and third accesses are a read of `CFG_BASE`+0x14 and then a write back to it. The write keeps bits 31:16 of the read value and places 0x2EF in bits 15:0.
- R3: Calibration is started by writing 0x1 to `CFG_BASE`+0x0C. That register is then read until bit 0 reads 0.
- R4: The step order is fixed: unlock, reference period update, calibrate, isolate, reload, pad mux, de-isolate, lock. Reload writes 0x2 to `CFG_BASE`+0x0C and reads until bit 1 reads 0.
- R5: An isolate or de-isolate step has six accesses, in this order:
  - write 1 to `PM_ADDR`;
  - read `PM_ADDR` until bit 1 is 1;
  - write `ISO_ADDR` (0x4 to isolate, 0x0 to release);
  - one read of `ISO_ADDR`;
  - write 0 to `PM_ADDR`;
  - read `PM_ADDR` until bit 1 is 0.
- R6: A poll issues at most `POLL_TRIES` reads. A match on the last permitted read still succeeds. `POLL_TRIES` reads without a match fail the step.
- R7: On a failure, the remaining steps are skipped and the next access is the lock write. `err_code` is set to the step's one-hot code: calibration 0x1, de-isolation 0x2, isolation 0x4, reload 0x8. `pass` is 1 exactly when `err_code` is 0.
- R8: `done` is high for exactly one cycle per run. `pass` and `err_code` keep their values while the block is idle, until the next accepted start.
- R9: A start pulse while `busy` is high has no effect: no extra accesses and no extra `done`.
- R10: A request is held stable while `bus_req_ready` is low. No new request is raised while a response is pending.
- R11: Between reload and de-isolation, `mux_req` rises and stays high until `mux_ack` is sampled high. No bus access happens meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, honoured only when idle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run ended with no error |
| err_code | output | 4 | One-hot failure code of the last run |
| bus_req_valid | output | 1 | Request valid |
| bus_req_ready | input | 1 | Request accepted when high with valid |
| bus_req_write | output | 1 | 1 = write, 0 = read |
| bus_req_addr | output | ADDR_W | Request address |
| bus_req_wdata | output | 32 | Write data |
| bus_rsp_valid | input | 1 | Response for the outstanding request |
| bus_rsp_rdata | input | 32 | Read data of the response |
| mux_req | output | 1 | Pad mux programming request |
| mux_ack | input | 1 | Pad mux programming finished |

## Verification
The bench builds the block with `POLL_TRIES` set to 8, so a failed poll costs only a handful of cycles. This makes every timeout branch reachable: calibration, isolation, reload and de-isolation. It also makes the boundary case reachable, where the match arrives on exactly the eighth read. The address parameters are set to small distinct values, so that a bus model in the bench can decode the configuration, power-control and isolation registers separately.

// File: rtl/iodly_pkg.sv
package iodly_pkg;
  localparam int DW      = 32;
  localparam int IDX_W   = 5;
  localparam int ERR_W   = 4;
  localparam int LOCK_IX = 19;

  localparam logic [DW-1:0] KEY_OPEN  = 32'h0000_AAAA;
  localparam logic [DW-1:0] KEY_CLOSE = 32'h0000_AAAB;
  localparam logic [DW-1:0] REF_PER   = 32'h0000_02EF;
  localparam logic [DW-1:0] REF_MASK  = 32'h0000_FFFF;

  localparam logic [7:0] OFF_KEY = 8'h2C;
  localparam logic [7:0] OFF_CTL = 8'h0C;
  localparam logic [7:0] OFF_PER = 8'h14;

  localparam logic [ERR_W-1:0] E_CAL   = 4'h1;
  localparam logic [ERR_W-1:0] E_UNISO = 4'h2;
  localparam logic [ERR_W-1:0] E_ISO   = 4'h4;
  localparam logic [ERR_W-1:0] E_LOAD  = 4'h8;

  typedef enum logic [2:0] {OP_WR, OP_RD, OP_RMW, OP_POLL, OP_MUX} op_e;
  typedef enum logic [1:0] {AS_CFG, AS_PM, AS_ISO} asel_e;

  typedef struct packed {
    op_e              kind;
    asel_e            sel;
    logic [7:0]       off;
    logic [DW-1:0]    data;   // write value, field value or poll expectation
    logic [DW-1:0]    mask;   // RMW field or poll compare mask
    logic [ERR_W-1:0] err;
  } step_t;

  function automatic step_t mk(op_e k, asel_e s, logic [7:0] o,
                               logic [DW-1:0] d, logic [DW-1:0] m,
                               logic [ERR_W-1:0] e);
    step_t r;
    r.kind = k; r.sel = s; r.off = o; r.data = d; r.mask = m; r.err = e;
    return r;
  endfunction

  // Six-access pad isolation handshake, shared by isolate and release.
  function automatic step_t pad_step(logic [2:0] k, logic iso);
    logic [ERR_W-1:0] e;
    e = iso ? E_ISO : E_UNISO;
    case (k)
      3'd0:    return mk(OP_WR,   AS_PM,  8'h0, 32'h1, 32'h0, 4'h0);
      3'd1:    return mk(OP_POLL, AS_PM,  8'h0, 32'h2, 32'h2, e);
      3'd2:    return mk(OP_WR,   AS_ISO, 8'h0, {29'd0, iso, 2'b00}, 32'h0, 4'h0);
      3'd3:    return mk(OP_RD,   AS_ISO, 8'h0, 32'h0, 32'h0, 4'h0);
      3'd4:    return mk(OP_WR,   AS_PM,  8'h0, 32'h0, 32'h0, 4'h0);
      default: return mk(OP_POLL, AS_PM,  8'h0, 32'h0, 32'h2, e);
    endcase
  endfunction
endpackage

// File: rtl/iodly_step_rom.sv
module iodly_step_rom
  import iodly_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);
  always_comb begin
    case (idx)
      5'd0:  step = mk(OP_WR,   AS_CFG, OFF_KEY, KEY_OPEN, 32'h0, 4'h0);
      5'd1:  step = mk(OP_RMW,  AS_CFG, OFF_PER, REF_PER, REF_MASK, 4'h0);
      5'd2:  step = mk(OP_WR,   AS_CFG, OFF_CTL, 32'h1, 32'h0, 4'h0);
      5'd3:  step = mk(OP_POLL, AS_CFG, OFF_CTL, 32'h0, 32'h1, E_CAL);
      5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9:
             step = pad_step(3'(idx - 5'd4), 1'b1);
      5'd10: step = mk(OP_WR,   AS_CFG, OFF_CTL, 32'h2, 32'h0, 4'h0);
      5'd11: step = mk(OP_POLL, AS_CFG, OFF_CTL, 32'h0, 32'h2, E_LOAD);
      5'd12: step = mk(OP_MUX,  AS_CFG, 8'h0, 32'h0, 32'h0, 4'h0);
      5'd13, 5'd14, 5'd15, 5'd16, 5'd17, 5'd18:
             step = pad_step(3'(idx - 5'd13), 1'b0);
      default: step = mk(OP_WR, AS_CFG, OFF_KEY, KEY_CLOSE, 32'h0, 4'h0);
    endcase
  end
endmodule

// File: rtl/iodly_try_cnt.sv
module iodly_try_cnt #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/iodly_recal_seq.sv
module iodly_recal_seq
  import iodly_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'h0000_4000,
  parameter logic [ADDR_W-1:0] PM_ADDR  = 32'h0000_5020,
  parameter logic [ADDR_W-1:0] ISO_ADDR = 32'h0000_63FC,
  parameter int              POLL_TRIES = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ERR_W-1:0]  err_code,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_write,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DW-1:0]     bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic [DW-1:0]     bus_rsp_rdata,
  output logic              mux_req,
  input  logic              mux_ack
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_e;

  st_e              st_q;
  logic [IDX_W-1:0] idx_q;
  logic             rmw_q;
  logic [DW-1:0]    hold_q;
  logic [ERR_W-1:0] err_q;
  logic             pass_q;
  step_t            cur;
  logic             try_last, try_clr, try_inc;
  logic             is_mux, rsp_take, poll_hit, adv, fail, retry, rmw_first;

  iodly_step_rom u_rom (.idx(idx_q), .step(cur));

  iodly_try_cnt #(.LIMIT(POLL_TRIES)) u_try (
    .clk(clk), .rst_n(rst_n), .clr(try_clr), .inc(try_inc), .last(try_last)
  );

  assign is_mux   = (cur.kind == OP_MUX);
  assign rsp_take = (st_q == S_WAIT) && bus_rsp_valid;
  assign poll_hit = ((bus_rsp_rdata & cur.mask) == cur.data);

  always_comb begin
    adv = 1'b0; fail = 1'b0; retry = 1'b0; rmw_first = 1'b0;
    if (st_q == S_ISSUE && is_mux && mux_ack) adv = 1'b1;
    if (rsp_take) begin
      unique case (cur.kind)
        OP_POLL: begin
          adv   = poll_hit;
          fail  = !poll_hit && try_last;
          retry = !poll_hit && !try_last;
        end
        OP_RMW:  begin
          adv       = rmw_q;
          rmw_first = !rmw_q;
        end
        default: adv = 1'b1;
      endcase
    end
  end

  assign try_clr = adv || fail || (st_q == S_IDLE);
  assign try_inc = retry;

  // Bus request side
  assign bus_req_valid = (st_q == S_ISSUE) && !is_mux;
  assign bus_req_write = (cur.kind == OP_WR) || (cur.kind == OP_RMW && rmw_q);
  assign bus_req_wdata = (cur.kind == OP_RMW) ? ((hold_q & ~cur.mask) | cur.data)
                                              : cur.data;
  always_comb begin
    unique case (cur.sel)
      AS_PM:   bus_req_addr = PM_ADDR;
      AS_ISO:  bus_req_addr = ISO_ADDR;
      default: bus_req_addr = CFG_BASE + ADDR_W'(cur.off);
    endcase
  end

  assign mux_req = (st_q == S_ISSUE) && is_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      rmw_q  <= 1'b0;
      hold_q <= '0;
      err_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start) begin
          st_q   <= S_ISSUE;
          idx_q  <= '0;
          rmw_q  <= 1'b0;
          err_q  <= '0;
          pass_q <= 1'b0;
        end
        S_ISSUE: begin
          if (bus_req_valid && bus_req_ready) st_q <= S_WAIT;
          else if (adv) begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_WAIT: begin
          if (rmw_first) begin
            hold_q <= bus_rsp_rdata;
            rmw_q  <= 1'b1;
            st_q   <= S_ISSUE;
          end else if (retry) begin
            st_q <= S_ISSUE;
          end else if (fail) begin
            err_q <= cur.err;
            idx_q <= IDX_W'(LOCK_IX);
            st_q  <= S_ISSUE;
          end else if (adv) begin
            rmw_q <= 1'b0;
            if (idx_q == IDX_W'(LOCK_IX)) begin
              st_q   <= S_DONE;
              pass_q <= (err_q == '0);
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= S_ISSUE;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign done     = (st_q == S_DONE);
  assign pass     = pass_q;
  assign err_code = err_q;
endmodule

// File: rtl/iodly_recal_chk.sv
module iodly_recal_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [3:0]        err_code,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic              bus_req_write,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic [31:0]       bus_req_wdata,
  input logic              bus_rsp_valid,
  input logic              mux_req,
  input logic              mux_ack
);
  logic pend_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              pend_q <= 1'b0;
    else if (bus_req_valid && bus_req_ready) pend_q <= 1'b1;
    else if (bus_rsp_valid)                  pend_q <= 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr)
      && $stable(bus_req_wdata) && $stable(bus_req_write)); // R10
  AST_ONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !pend_q); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_code)); // R7
  AST_PASS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass == (err_code == 4'h0))); // R7
  AST_RESULT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(err_code) && $stable(pass)); // R8
  AST_MUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mux_req && !mux_ack |=> mux_req); // R11
  AST_MUX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mux_req |-> !bus_req_valid); // R11
endmodule

bind iodly_recal_seq iodly_recal_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .pass(pass), .err_code(err_code), .bus_req_valid(bus_req_valid),
  .bus_req_ready(bus_req_ready), .bus_req_write(bus_req_write),
  .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
  .bus_rsp_valid(bus_rsp_valid), .mux_req(mux_req), .mux_ack(mux_ack)
);

// File: tb/iodly_recal_seq_test.sv
module iodly_recal_seq_test;
  localparam int          TRIES = 8;
  localparam logic [31:0] CFG   = 32'h0000_1000;
  localparam logic [31:0] PM    = 32'h0000_2020;
  localparam logic [31:0] ISO   = 32'h0000_03FC;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, pass, req_valid, req_write, mux_req;
  logic req_ready = 1'b0, rsp_valid = 1'b0, mux_ack = 1'b0;
  logic [3:0]  err_code;
  logic [31:0] req_addr, req_wdata, rsp_rdata = '0;

  always #2 clk = ~clk;

  iodly_recal_seq #(.ADDR_W(32), .CFG_BASE(CFG), .PM_ADDR(PM), .ISO_ADDR(ISO),
                    .POLL_TRIES(TRIES)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pass(pass), .err_code(err_code), .bus_req_valid(req_valid),
    .bus_req_ready(req_ready), .bus_req_write(req_write),
    .bus_req_addr(req_addr), .bus_req_wdata(req_wdata),
    .bus_rsp_valid(rsp_valid), .bus_rsp_rdata(rsp_rdata),
    .mux_req(mux_req), .mux_ack(mux_ack));

  int checks = 0, errors = 0;

  task automatic check(bit ok, string tag, logic [65:0] act, logic [65:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard: item = {mux, write, addr, data}
  typedef struct { logic [65:0] item; string tag; } exp_t;
  exp_t exq[$];

  task automatic push(bit mx, bit wr, logic [31:0] a, logic [31:0] d, string tag);
    exp_t e;
    e.item = {mx, wr, a, d};
    e.tag  = tag;
    exq.push_back(e);
  endtask

  task automatic observe(logic [65:0] act);
    exp_t e;
    if (exq.size() == 0) check(1'b0, "R9 extra access", act, '0);
    else begin
      e = exq.pop_front();
      check(act == e.item, e.tag, act, e.item);
    end
  endtask

  // Slave model state
  int cal_k, rel_k, stuck_n;
  int cal_left, rel_left, ov_sets, cyc;
  logic ov;
  logic [31:0] per_reg, iso_reg, pend_data;
  bit pend, mux_seen;
  int mux_wait;
  int done_cnt;

  task automatic slave_reset();
    cal_left = 0; rel_left = 0; ov_sets = 0; ov = 1'b0;
    per_reg = 32'hABCD_1234; iso_reg = '0;
  endtask

  // Bus slave, pad-mux agent and monitor, all acting at the falling edge
  initial begin
    pend = 0; mux_seen = 0; mux_wait = 0; cyc = 0; done_cnt = 0;
    slave_reset();
    forever begin
      @(negedge clk);
      cyc++;
      rsp_valid = 1'b0;
      mux_ack   = 1'b0;
      if (pend) begin
        rsp_valid = 1'b1; rsp_rdata = pend_data; pend = 0;
      end
      req_ready = (cyc % 3) != 2;
      if (rst_n && req_valid && req_ready) begin
        observe({1'b0, req_write, req_addr, req_write ? req_wdata : 32'h0});
        pend = 1; pend_data = '0;
        if (req_write) begin
          if (req_addr == CFG + 32'h0C) begin
            if (req_wdata[0]) cal_left = cal_k;
            if (req_wdata[1]) rel_left = rel_k;
          end else if (req_addr == CFG + 32'h14) per_reg = req_wdata;
          else if (req_addr == PM) begin
            ov = req_wdata[0];
            if (ov) ov_sets++;
          end else if (req_addr == ISO) iso_reg = req_wdata;
        end else begin
          if (req_addr == CFG + 32'h0C) begin
            pend_data = {30'd0, rel_left > 0, cal_left > 0};
            if (cal_left > 0) cal_left--;
            else if (rel_left > 0) rel_left--;
          end else if (req_addr == CFG + 32'h14) pend_data = per_reg;
          else if (req_addr == PM)
            pend_data = {30'd0, ov && (ov_sets != stuck_n), ov};
          else if (req_addr == ISO) pend_data = iso_reg;
        end
      end
      if (mux_req) begin
        if (!mux_seen) begin observe({1'b1, 1'b0, 64'h0}); mux_seen = 1; end
        mux_wait++;
        if (mux_wait == 3) begin mux_ack = 1'b1; mux_wait = 0; mux_seen = 0; end
      end
      if (done) done_cnt++;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pad_block(bit iso, bit stuck, output bit abort);
    string t = iso ? "R5 isolate" : "R5 release";
    abort = 0;
    push(0, 1, PM, 32'h1, t);
    if (stuck) begin
      for (int i = 0; i < TRIES; i++) push(0, 0, PM, 0, "R6 status poll limit");
      abort = 1;
      return;
    end
    push(0, 0, PM, 0, t);
    push(0, 1, ISO, iso ? 32'h4 : 32'h0, t);
    push(0, 0, ISO, 0, t);
    push(0, 1, PM, 32'h0, t);
    push(0, 0, PM, 0, t);
  endtask

  task automatic run_case(int ck, int rk, int sn, logic [3:0] exp_err,
                          bit busy_start, string name);
    bit ab;
    int n;
    cal_k = ck; rel_k = rk; stuck_n = sn;
    slave_reset();
    done_cnt = 0;
    exq.delete();
    push(0, 1, CFG + 32'h2C, 32'h0000_AAAA, "R1 unlock first");
    begin : build
      push(0, 0, CFG + 32'h14, 0, "R2 period read");
      push(0, 1, CFG + 32'h14, 32'hABCD_02EF, "R2 period write");
      push(0, 1, CFG + 32'h0C, 32'h1, "R3 calib start");
      n = (ck + 1 > TRIES) ? TRIES : ck + 1;
      for (int i = 0; i < n; i++) push(0, 0, CFG + 32'h0C, 0, "R3 calib poll R6");
      if (ck >= TRIES) disable build;
      pad_block(1, sn == 1, ab);
      if (ab) disable build;
      push(0, 1, CFG + 32'h0C, 32'h2, "R4 reload start");
      n = (rk + 1 > TRIES) ? TRIES : rk + 1;
      for (int i = 0; i < n; i++) push(0, 0, CFG + 32'h0C, 0, "R4 reload poll R6");
      if (rk >= TRIES) disable build;
      push(1, 0, 0, 0, "R11 mux step");
      pad_block(0, sn == 2, ab);
    end
    push(0, 1, CFG + 32'h2C, 32'h0000_AAAB, "R1 lock last R7");
    pulse_start();
    if (busy_start) begin
      repeat (25) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    for (int i = 0; i < 3000 && done_cnt == 0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    $display("case %s done", name);
    check(exq.size() == 0, "R4 all steps seen", 66'(exq.size()), 0);
    check(done_cnt == 1, busy_start ? "R9 single done" : "R8 single done",
          66'(done_cnt), 1);
    check(err_code == exp_err, "R7 err_code", 66'(err_code), 66'(exp_err));
    check(pass == (exp_err == 0), "R7 pass", 66'(pass), 66'(exp_err == 0));
    check(!busy, "R8 idle after done", 66'(busy), 0);
    repeat (10) @(negedge clk);
    check(err_code == exp_err && done_cnt == 1, "R8 result held",
          66'({done_cnt[3:0], err_code}), 66'({4'd1, exp_err}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!busy && !done && !req_valid && !mux_req && err_code == 0,
          "R8 reset state", 66'({busy, done, req_valid, mux_req, err_code}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case(3, 2, 0, 4'h0, 1'b1, "nominal with busy start R9");
    run_case(TRIES - 1, TRIES - 1, 0, 4'h0, 1'b0, "match on last read R6");
    run_case(TRIES + 5, 2, 0, 4'h1, 1'b0, "calibration timeout");
    run_case(1, 2, 1, 4'h4, 1'b0, "isolation timeout");
    run_case(1, TRIES, 0, 4'h8, 1'b0, "reload timeout");
    run_case(0, 0, 2, 4'h2, 1'b0, "release timeout");
    run_case(2, 1, 0, 4'h0, 1'b0, "recovery after failure R10");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule